// File: doc/BRIEF.md
# Remote-Control Wake and Power-State Controller

This block sits between an infrared code decoder and a host computer. It receives complete 13-bit remote-control code words and a level that says whether the host has power. From these it drives an open-drain wake request and an infrared pass-through line toward the host. It tracks three modes: host off, host starting up after a remote wake, and host running.

While the host is off, a press of the power key produces a timed wake pulse. The block then enters a startup mode. For a fixed window it does not react to the host-power input, because the host may drop power briefly while it boots. Throughout the startup mode the pass-through line is held low. The host can read that low level to learn that the remote caused the power-up. The block leaves this mode on the next fresh key press. If the host powers up by other means, the block goes straight to the running mode. In the running mode the raw infrared level is echoed to the host. Repeated code words, as sent while a key is held, are filtered by comparing each word with the last accepted word.

Top module: `rc_wake_ctrl`

## Requirements
- R1: During and after reset `mode_o` is 0 (off), `wake_oe` is 0 and `ir_pass` is 0.
- R2: `mode_o` encodes off as 0, starting as 1 and running as 2; the value 3 never appears.
- R3: In off mode, a fresh word is the power key when bits 12 and 10..8 are all 1 and bits 7..0 equal 0xBD; bit 11 is the toggle bit and is ignored. Such a word raises `wake_oe` on the next edge. Without host power, `wake_oe` stays high for WAKE_CYC cycles, and then the mode becomes 1.
- R4: If `host_pwr` is 1 while the wake pulse is active, `wake_oe` drops and the mode becomes 1 on the next edge.
- R5: Once the wake pulse ends, for HOLD_CYC cycles the mode stays 1 whatever `host_pwr` or the code inputs do.
- R6: In mode 1, `ir_pass` is 0. Once the hold window has ended, `host_pwr` at 0 returns the mode to 0.
- R7: Once the hold window has ended, a valid word that differs from the last accepted word moves mode 1 to mode 2, whether or not it is the power key. A word equal to the last accepted word is ignored.
- R8: In mode 2, `ir_pass` equals `ir_level`, and code words are ignored. `host_pwr` at 0 moves the mode to 0 on the next edge.
- R9: In mode 0 with no wake pulse active, `host_pwr` at 1 moves the mode to 2 on the next edge. With an idle (high) infrared level, `ir_pass` then reads 1.
- R10: In mode 0, a fresh word that is not the power key leaves the mode at 0 and does not raise `wake_oe`.
- R11: The last accepted word is cleared to zero whenever the mode changes to 0 or to 2. As a result, the same power-key word wakes the host again after power is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | One-cycle strobe: `code` holds a complete word |
| code | input | 13 | Decoded remote-control word |
| host_pwr | input | 1 | 1 while the host has power (already synchronised) |
| ir_level | input | 1 | Raw infrared receiver level (already synchronised) |
| wake_oe | output | 1 | Open-drain enable; 1 pulls the wake line low |
| ir_pass | output | 1 | Infrared pass-through / wake-source flag to the host |
| mode_o | output | 2 | Current mode: 0 off, 1 starting, 2 running |

## Verification
A cycle-by-cycle table exercises the mode changes and the echo path. It presents a non-power key while off, which shows that keys are filtered before a wake. It raises host power without a key, which separates the direct-to-running path from the wake path. It toggles the infrared level while running and sends a power key while running, which shows that the line is echoed and the key has no effect. Directed sequences then measure the full wake pulse against one that host power cuts short. They drop host power inside and after the hold window, which shows glitch immunity versus a real loss. They repeat the same power word and then its toggled form, which separates the repeat filter from the clearing of the last word on mode changes.

// File: rtl/rc_wake_ctrl.sv
module rc_wake_ctrl #(
  parameter int WAKE_CYC = 150000,
  parameter int HOLD_CYC = 10000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        code_valid,
  input  logic [12:0] code,
  input  logic        host_pwr,
  input  logic        ir_level,
  output logic        wake_oe,
  output logic        ir_pass,
  output logic [1:0]  mode_o
);
  localparam int MAXC = (WAKE_CYC > HOLD_CYC) ? WAKE_CYC : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [1:0] M_OFF = 2'd0, M_START = 2'd1, M_ON = 2'd2;

  logic [1:0]    mode_q;
  logic          wake_q;
  logic [CW-1:0] cnt_q;
  logic [12:0]   last_q;

  wire fresh  = code_valid && (code != last_q);
  wire is_pwr = code[12] && (code[10:8] == 3'b111) && (code[7:0] == 8'hBD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      wake_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      case (mode_q)
        M_OFF: begin
          if (wake_q) begin
            if (host_pwr || cnt_q == CW'(WAKE_CYC - 1)) begin
              wake_q <= 1'b0;
              mode_q <= M_START;
              cnt_q  <= CW'(HOLD_CYC);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end else if (host_pwr) begin
            mode_q <= M_ON;
            last_q <= '0;
          end else if (fresh) begin
            last_q <= code;
            if (is_pwr) begin
              wake_q <= 1'b1;
              cnt_q  <= '0;
            end
          end
        end
        M_START: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!host_pwr) begin
            mode_q <= M_OFF;
            last_q <= '0;
          end else if (fresh) begin
            mode_q <= M_ON;
            last_q <= '0;
          end
        end
        M_ON: begin
          if (!host_pwr) begin
            mode_q <= M_OFF;
            last_q <= '0;
          end
        end
        default: mode_q <= M_OFF;
      endcase
    end
  end

  assign wake_oe = wake_q;
  assign ir_pass = (mode_q == M_ON) && ir_level;
  assign mode_o  = mode_q;
endmodule

// File: rtl/rc_wake_ctrl_chk.sv
module rc_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_pwr,
  input logic       wake_oe,
  input logic       ir_pass,
  input logic [1:0] mode_o
);
  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  p_wake_in_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_oe |-> mode_o == 2'd0);

  p_wake_end_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_oe) |-> mode_o == 2'd1);

  p_pwr_cuts_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_oe && host_pwr) |=> (!wake_oe && mode_o == 2'd1));

  p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'd1 |-> !ir_pass);

  p_on_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !host_pwr) |=> mode_o == 2'd0);

  p_off_pwr_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !wake_oe && host_pwr) |=> mode_o == 2'd2);
endmodule

bind rc_wake_ctrl rc_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_pwr(host_pwr),
  .wake_oe(wake_oe), .ir_pass(ir_pass), .mode_o(mode_o)
);

// File: tb/rc_wake_ctrl_bench.sv
module rc_wake_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int WAKE = 4;
  localparam int HOLD = 6;
  localparam logic [12:0] PWR   = 13'h17BD;
  localparam logic [12:0] PWR_T = 13'h1FBD;
  localparam logic [12:0] OTHER = 13'h17BC;

  logic clk = 0, rst_n = 0, code_valid = 0, host_pwr = 0, ir_level = 1;
  logic [12:0] code = '0;
  logic wake_oe, ir_pass;
  logic [1:0] mode_o;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rc_wake_ctrl #(.WAKE_CYC(WAKE), .HOLD_CYC(HOLD)) u_rc_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
    .host_pwr(host_pwr), .ir_level(ir_level),
    .wake_oe(wake_oe), .ir_pass(ir_pass), .mode_o(mode_o)
  );

  // {valid, code, host_pwr, ir_level, exp_mode, exp_wake, exp_pass}
  localparam int NV = 7;
  localparam logic [19:0] TBL [NV] = '{
    {1'b1, OTHER, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},  // R10 other key ignored
    {1'b0, 13'h0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1},  // R9 power without wake
    {1'b0, 13'h0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0},  // R8 echo low
    {1'b0, 13'h0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1},  // R8 echo high
    {1'b1, PWR,   1'b1, 1'b0, 2'd2, 1'b0, 1'b0},  // R8 key ignored in on
    {1'b0, 13'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},  // R8 power loss
    {1'b0, 13'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}   // R2 stays off
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [12:0] w);
    code = w; code_valid = 1; tick(); code_valid = 0;
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    chk("R1 mode", mode_o, 0);
    chk("R1 wake", wake_oe, 0);
    chk("R1 pass", ir_pass, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      code_valid = TBL[i][19];
      code       = TBL[i][18:6];
      host_pwr   = TBL[i][5];
      ir_level   = TBL[i][4];
      tick();
      code_valid = 0;
      chk("R8/R9/R10 table mode", mode_o, int'(TBL[i][3:2]));
      chk("R3 table wake", wake_oe, int'(TBL[i][1]));
      chk("R8 table pass", ir_pass, int'(TBL[i][0]));
    end

    // R3: full wake pulse width, then startup mode
    send(PWR);
    chk("R3 wake raised", wake_oe, 1);
    n = 1;
    for (int k = 0; k < 50 && wake_oe; k++) begin
      tick();
      if (wake_oe) n++;
    end
    chk("R3 pulse width", n, WAKE);
    chk("R3 mode after pulse", mode_o, 1);
    chk("R6 pass low in start", ir_pass, 0);

    // R5: power dropout and codes ignored during the hold window
    host_pwr = 0;
    for (int k = 0; k < HOLD; k++) begin
      if (k == 2) begin code = OTHER; code_valid = 1; end
      tick();
      code_valid = 0;
      chk("R5 held in start", mode_o, 1);
    end
    host_pwr = 1;
    tick();
    chk("R5 start after window", mode_o, 1);

    // R7: repeat ignored, fresh word moves to running
    send(PWR);
    chk("R7 repeat ignored", mode_o, 1);
    chk("R6 still low", ir_pass, 0);
    send(PWR_T);
    chk("R7 fresh word to on", mode_o, 2);
    chk("R8 echo after start", ir_pass, 1);

    // R11: loss of power clears last word; same word wakes again
    host_pwr = 0; tick();
    chk("R8 loss to off", mode_o, 0);
    send(PWR_T);
    chk("R11 cleared word wakes", wake_oe, 1);

    // R4: host power cuts pulse short
    host_pwr = 1; tick();
    chk("R4 wake released", wake_oe, 0);
    chk("R4 mode start", mode_o, 1);

    // R6: real loss after window returns to off
    host_pwr = 0;
    for (int k = 0; k < HOLD; k++) tick();
    chk("R6 still start at window end", mode_o, 1);
    tick();
    chk("R6 off after window", mode_o, 0);
    chk("R6 no wake", wake_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule